// File: doc/BRIEF.md
# Counted Loop Branch Resolver

This block resolves one counted-loop branch for a small processor datapath. A request carries an opcode byte, a signed 8-bit displacement, the current 32-bit counter register, the zero flag, an address-width select (16 or 32 bits) and the address of the next sequential instruction. The block steps the counter down by one, decides from the stepped value (and, for two of the variants, from the zero flag) whether the branch is taken, and returns the new counter value, the taken flag and the address to fetch next.

Three variants are served: a plain counted loop, a loop that continues only while the zero flag is set, and a loop that continues only while it is clear. Any other opcode is reported as illegal and leaves the counter untouched. Requests and results move over a valid/ready pair on each side, with one registered result per accepted request. The zero flag is an input only; the block has no path that writes it.

Top module: `loop_branch_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `resp_valid` is 0 and `req_ready` is 1.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1; its result appears with `resp_valid` = 1 after that edge. `req_ready` is 1 exactly when `resp_valid` is 0 or `resp_ready` is 1, and a pending result holds all its fields unchanged until `resp_ready` is seen.
- R3: With `req_addr32` = 1 and a legal opcode, `resp_count` equals `req_count` minus one modulo 2^32.
- R4: With `req_addr32` = 0 and a legal opcode, bits 15:0 of `resp_count` equal bits 15:0 of `req_count` minus one modulo 2^16 (0x0000 becomes 0xFFFF) and bits 31:16 are passed through unchanged.
- R5: Opcode 0xE2 is taken exactly when the stepped counter of the active width is non-zero; an incoming zero therefore wraps and is taken.
- R6: Opcode 0xE1 is taken exactly when the stepped counter of the active width is non-zero and `req_zf` is 1.
- R7: Opcode 0xE0 is taken exactly when the stepped counter of the active width is non-zero and `req_zf` is 0.
- R8: When taken, `resp_next_ip` is `req_next_ip` plus the sign-extended displacement (range -128 to +127) modulo 2^32; with `req_addr32` = 0 the sum is cut to its low 16 bits and bits 31:16 are 0.
- R9: When a legal opcode is not taken, `resp_next_ip` equals `req_next_ip`.
- R10: An opcode other than 0xE0, 0xE1, 0xE2 gives `resp_illegal` = 1, `resp_taken` = 0, `resp_count` equal to `req_count` and `resp_next_ip` equal to `req_next_ip`.
- R11: Opcodes 0xE0, 0xE1 and 0xE2 give `resp_illegal` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_opcode | input | 8 | Loop opcode byte |
| req_disp | input | 8 | Signed branch displacement |
| req_count | input | 32 | Current counter register |
| req_zf | input | 1 | Zero flag |
| req_addr32 | input | 1 | 1: 32-bit counter and address, 0: 16-bit |
| req_next_ip | input | 32 | Address of the next sequential instruction |
| resp_valid | output | 1 | Result present |
| resp_ready | input | 1 | Consumer takes the result |
| resp_count | output | 32 | Updated counter register |
| resp_taken | output | 1 | Branch taken |
| resp_next_ip | output | 32 | Address to fetch next |
| resp_illegal | output | 1 | Opcode is not a loop variant |

## Verification
The assertions take for granted that request fields are meaningful only in the cycle the request is accepted, and that the displacement is read as a two's-complement byte; they sample inputs only under the acceptance condition and compare the registered result one cycle later. The stimulus holds every request field steady from the falling edge before acceptance until after it, and sweeps both address widths, every legal opcode with several illegal neighbours, both flag values, counters at the 16-bit and 32-bit wrap points and displacements at both ends of their range. Stall behaviour is driven separately with the consumer held off while a second request waits at the input.

// File: rtl/loop_br_pkg.sv
// Shared constants and types for the counted loop branch resolver.
// Assumes a byte-wide opcode and a two's-complement displacement.
package loop_br_pkg;

    localparam int CNT_W    = 32;
    localparam int IP_W     = 32;
    localparam int DISP_W   = 8;
    localparam int NARROW_W = 16;
    localparam int OPC_W    = 8;

    localparam logic [OPC_W-1:0] OPC_WHILE_NE = 8'hE0;
    localparam logic [OPC_W-1:0] OPC_WHILE_EQ = 8'hE1;
    localparam logic [OPC_W-1:0] OPC_COUNT    = 8'hE2;

    typedef enum logic [1:0] {
        VAR_COUNT = 2'd0,
        VAR_EQ    = 2'd1,
        VAR_NE    = 2'd2,
        VAR_BAD   = 2'd3
    } loop_var_e;

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             taken;
        logic [IP_W-1:0]  next_ip;
        logic             illegal;
    } loop_res_t;

endpackage

// File: rtl/lbr_opcode_decode.sv
// Maps an opcode byte onto a loop variant.
// Assumes only the three loop opcodes are legal; all else decodes to VAR_BAD.
module lbr_opcode_decode
    import loop_br_pkg::*;
#(
    parameter int W = OPC_W
) (
    input  logic [W-1:0] opcode,
    output loop_var_e    variant
);

    // Purpose: select the variant from the exact opcode value.
    always_comb begin
        unique case (opcode)
            W'(OPC_COUNT):    variant = VAR_COUNT;
            W'(OPC_WHILE_EQ): variant = VAR_EQ;
            W'(OPC_WHILE_NE): variant = VAR_NE;
            default:          variant = VAR_BAD;
        endcase
    end

endmodule

// File: rtl/lbr_count_step.sv
// Decrements the counter at the active width and flags a zero result.
// Assumes NARROW_W < CNT_W; in narrow mode the upper bits pass through.
module lbr_count_step #(
    parameter int CNT_W    = 32,
    parameter int NARROW_W = 16
) (
    input  logic [CNT_W-1:0] count_in,
    input  logic             wide,
    output logic [CNT_W-1:0] count_out,
    output logic             stepped_zero
);

    localparam int HI_W = CNT_W - NARROW_W;

    logic [CNT_W-1:0]    wide_dec;
    logic [NARROW_W-1:0] narrow_dec;
    logic [HI_W-1:0]     hi_keep;

    // Purpose: form both candidate decrements in parallel.
    always_comb begin
        wide_dec   = count_in - CNT_W'(1);
        narrow_dec = count_in[NARROW_W-1:0] - NARROW_W'(1);
        hi_keep    = count_in[CNT_W-1:NARROW_W];
    end

    // Purpose: pick the active width and test the stepped value for zero.
    always_comb begin
        if (wide) begin
            count_out    = wide_dec;
            stepped_zero = (wide_dec == '0);
        end else begin
            count_out    = {hi_keep, narrow_dec};
            stepped_zero = (narrow_dec == '0);
        end
    end

endmodule

// File: rtl/lbr_target_gen.sv
// Computes the fetch address: sequential, or next address plus displacement.
// Assumes a two's-complement displacement narrower than the address.
module lbr_target_gen #(
    parameter int IP_W     = 32,
    parameter int DISP_W   = 8,
    parameter int NARROW_W = 16
) (
    input  logic [IP_W-1:0]   seq_ip,
    input  logic [DISP_W-1:0] disp,
    input  logic              wide,
    input  logic              take,
    output logic [IP_W-1:0]   fetch_ip
);

    localparam int EXT_W = IP_W - DISP_W;
    localparam int PAD_W = IP_W - NARROW_W;

    logic [IP_W-1:0] disp_ext;
    logic [IP_W-1:0] sum;
    logic [IP_W-1:0] target;

    // Purpose: sign-extend the displacement and add it to the next address.
    always_comb begin
        disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
        sum      = seq_ip + disp_ext;
    end

    // Purpose: cut the target to the narrow width when required, then choose.
    always_comb begin
        if (wide) target = sum;
        else      target = {{PAD_W{1'b0}}, sum[NARROW_W-1:0]};
        fetch_ip = take ? target : seq_ip;
    end

endmodule

// File: rtl/loop_branch_unit.sv
// Counted loop branch resolver with a valid/ready request and result pair.
// Assumes request fields are stable while req_valid is high; result is
// registered, one per accepted request, and held until resp_ready.
module loop_branch_unit
    import loop_br_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [OPC_W-1:0] req_opcode,
    input  logic [DISP_W-1:0] req_disp,
    input  logic [CNT_W-1:0] req_count,
    input  logic             req_zf,
    input  logic             req_addr32,
    input  logic [IP_W-1:0]  req_next_ip,
    output logic             resp_valid,
    input  logic             resp_ready,
    output logic [CNT_W-1:0] resp_count,
    output logic             resp_taken,
    output logic [IP_W-1:0]  resp_next_ip,
    output logic             resp_illegal
);

    loop_var_e        variant;
    logic [CNT_W-1:0] stepped;
    logic             stepped_zero;
    logic             take;
    logic [IP_W-1:0]  fetch_ip;
    loop_res_t        comb_res;
    loop_res_t        res_q;
    logic             valid_q;
    logic             accept;

    lbr_opcode_decode #(.W(OPC_W)) u_dec (
        .opcode  (req_opcode),
        .variant (variant)
    );

    lbr_count_step #(.CNT_W(CNT_W), .NARROW_W(NARROW_W)) u_step (
        .count_in     (req_count),
        .wide         (req_addr32),
        .count_out    (stepped),
        .stepped_zero (stepped_zero)
    );

    lbr_target_gen #(.IP_W(IP_W), .DISP_W(DISP_W), .NARROW_W(NARROW_W)) u_tgt (
        .seq_ip   (req_next_ip),
        .disp     (req_disp),
        .wide     (req_addr32),
        .take     (take),
        .fetch_ip (fetch_ip)
    );

    // Purpose: branch condition from the stepped counter and the zero flag.
    always_comb begin
        unique case (variant)
            VAR_COUNT: take = !stepped_zero;
            VAR_EQ:    take = !stepped_zero && req_zf;
            VAR_NE:    take = !stepped_zero && !req_zf;
            default:   take = 1'b0;
        endcase
    end

    // Purpose: assemble the result, leaving the counter alone when illegal.
    always_comb begin
        comb_res.illegal = (variant == VAR_BAD);
        comb_res.taken   = take;
        comb_res.next_ip = fetch_ip;
        comb_res.count   = comb_res.illegal ? req_count : stepped;
    end

    // Purpose: handshake; a slot frees when empty or being drained.
    always_comb begin
        req_ready = !valid_q || resp_ready;
        accept    = req_valid && req_ready;
    end

    // Purpose: result register with its valid bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            res_q   <= '0;
        end else if (accept) begin
            valid_q <= 1'b1;
            res_q   <= comb_res;
        end else if (resp_ready) begin
            valid_q <= 1'b0;
        end
    end

    // Purpose: drive the result ports from the register.
    always_comb begin
        resp_valid   = valid_q;
        resp_count   = res_q.count;
        resp_taken   = res_q.taken;
        resp_next_ip = res_q.next_ip;
        resp_illegal = res_q.illegal;
    end

endmodule

// File: rtl/lbr_checker.sv
// Property checker for loop_branch_unit, attached by bind below.
// Assumes request fields are meaningful only when a request is accepted.
module lbr_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic [7:0]  req_opcode,
    input logic [7:0]  req_disp,
    input logic [31:0] req_count,
    input logic        req_zf,
    input logic        req_addr32,
    input logic [31:0] req_next_ip,
    input logic        resp_valid,
    input logic        resp_ready,
    input logic [31:0] resp_count,
    input logic        resp_taken,
    input logic [31:0] resp_next_ip,
    input logic        resp_illegal
);

    logic acc;
    logic legal;
    logic [31:0] dext;

    // Purpose: helper terms shared by the properties.
    always_comb begin
        acc   = req_valid && req_ready;
        legal = (req_opcode == 8'hE0) || (req_opcode == 8'hE1) || (req_opcode == 8'hE2);
        dext  = {{24{req_disp[7]}}, req_disp};
    end

    AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> !resp_valid); // R1
    AST_ACCEPT_GIVES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> resp_valid); // R2
    AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_ready) |-> !req_ready); // R2
    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_count) && $stable(resp_taken)
                                         && $stable(resp_next_ip) && $stable(resp_illegal))); // R2
    AST_WIDE_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && legal && req_addr32) |=> (resp_count == $past(req_count) - 32'd1)); // R3
    AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !req_addr32) |=> (resp_count[31:16] == $past(req_count[31:16]))); // R4
    AST_WIDE_TAKEN_NZ: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_addr32) |=> (!resp_taken || resp_count != 32'd0)); // R5
    AST_EQ_NEEDS_ZF: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_opcode == 8'hE1 && !req_zf) |=> !resp_taken); // R6
    AST_NE_NEEDS_NZF: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_opcode == 8'hE0 && req_zf) |=> !resp_taken); // R7
    AST_WIDE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_addr32) |=> (!resp_taken || resp_next_ip == $past(req_next_ip) + $past(dext))); // R8
    AST_SEQ_WHEN_NT: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> (resp_taken || resp_next_ip == $past(req_next_ip))); // R9
    AST_ILLEGAL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !legal) |=> (resp_illegal && !resp_taken && resp_count == $past(req_count))); // R10
    AST_LEGAL_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && legal) |=> !resp_illegal); // R11

endmodule

bind loop_branch_unit lbr_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_opcode   (req_opcode),
    .req_disp     (req_disp),
    .req_count    (req_count),
    .req_zf       (req_zf),
    .req_addr32   (req_addr32),
    .req_next_ip  (req_next_ip),
    .resp_valid   (resp_valid),
    .resp_ready   (resp_ready),
    .resp_count   (resp_count),
    .resp_taken   (resp_taken),
    .resp_next_ip (resp_next_ip),
    .resp_illegal (resp_illegal)
);

// File: tb/tb_loop_branch_unit.sv
// Sweep bench for loop_branch_unit with an arithmetic reference model.
module tb_loop_branch_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [7:0]  req_opcode = '0;
    logic [7:0]  req_disp = '0;
    logic [31:0] req_count = '0;
    logic        req_zf = 1'b0;
    logic        req_addr32 = 1'b0;
    logic [31:0] req_next_ip = '0;
    logic        resp_valid;
    logic        resp_ready = 1'b1;
    logic [31:0] resp_count;
    logic        resp_taken;
    logic [31:0] resp_next_ip;
    logic        resp_illegal;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 0;

    always #5 clk = ~clk;

    loop_branch_unit dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_opcode(req_opcode), .req_disp(req_disp), .req_count(req_count),
        .req_zf(req_zf), .req_addr32(req_addr32), .req_next_ip(req_next_ip),
        .resp_valid(resp_valid), .resp_ready(resp_ready),
        .resp_count(resp_count), .resp_taken(resp_taken),
        .resp_next_ip(resp_next_ip), .resp_illegal(resp_illegal)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<150000 cycles", cycles);
            finish_run();
        end
    end

    // Reference model written from the requirements.
    task automatic model(input logic [7:0] op, input logic [7:0] d, input logic [31:0] c,
                         input logic z, input logic w, input logic [31:0] nip,
                         output logic [31:0] e_cnt, output logic e_tk,
                         output logic [31:0] e_ip, output logic e_ill);
        logic [31:0] act_cnt;
        logic [31:0] tgt;
        logic        nz;
        e_ill = !(op == 8'hE0 || op == 8'hE1 || op == 8'hE2);
        if (w) begin
            e_cnt   = c - 32'd1;
            act_cnt = e_cnt;
        end else begin
            e_cnt   = {c[31:16], 16'(c[15:0] - 16'd1)};
            act_cnt = {16'd0, e_cnt[15:0]};
        end
        nz = (act_cnt != 0);
        if (op == 8'hE2)      e_tk = nz;
        else if (op == 8'hE1) e_tk = nz && z;
        else if (op == 8'hE0) e_tk = nz && !z;
        else                  e_tk = 1'b0;
        if (e_ill) e_cnt = c;
        tgt = nip + {{24{d[7]}}, d};
        if (!w) tgt = {16'd0, tgt[15:0]};
        e_ip = e_tk ? tgt : nip;
    endtask

    task automatic drive(input logic [7:0] op, input logic [7:0] d, input logic [31:0] c,
                         input logic z, input logic w, input logic [31:0] nip);
        req_valid   = 1'b1;
        req_opcode  = op;
        req_disp    = d;
        req_count   = c;
        req_zf      = z;
        req_addr32  = w;
        req_next_ip = nip;
    endtask

    task automatic check_result(input logic [7:0] op, input logic [7:0] d, input logic [31:0] c,
                                input logic z, input logic w, input logic [31:0] nip);
        logic [31:0] e_cnt, e_ip;
        logic e_tk, e_ill;
        string t_cnt, t_tk, t_ip, t_il;
        model(op, d, c, z, w, nip, e_cnt, e_tk, e_ip, e_ill);
        t_cnt = e_ill ? "R10 count" : (w ? "R3 count" : "R4 count");
        t_tk  = e_ill ? "R10 taken" : (op == 8'hE2 ? "R5 taken" : (op == 8'hE1 ? "R6 taken" : "R7 taken"));
        t_ip  = e_ill ? "R10 next_ip" : (e_tk ? "R8 next_ip" : "R9 next_ip");
        t_il  = e_ill ? "R10 illegal" : "R11 illegal";
        chk("R2 resp_valid", {31'd0, resp_valid}, 32'd1);
        chk(t_cnt, resp_count, e_cnt);
        chk(t_tk,  {31'd0, resp_taken}, {31'd0, e_tk});
        chk(t_ip,  resp_next_ip, e_ip);
        chk(t_il,  {31'd0, resp_illegal}, {31'd0, e_ill});
    endtask

    task automatic txn(input logic [7:0] op, input logic [7:0] d, input logic [31:0] c,
                       input logic z, input logic w, input logic [31:0] nip);
        @(negedge clk);
        drive(op, d, c, z, w, nip);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check_result(op, d, c, z, w, nip);
    endtask

    logic [31:0] cnts [10] = '{32'h0, 32'h1, 32'h2, 32'h0000FFFF, 32'h00010000,
                               32'h00010001, 32'hFFFFFFFF, 32'h12340000, 32'hABCD0001, 32'h80000000};
    logic [7:0]  ops  [7]  = '{8'hE0, 8'hE1, 8'hE2, 8'h00, 8'hE3, 8'hDF, 8'hFF};
    logic [7:0]  disps [5] = '{8'h00, 8'h7F, 8'h80, 8'hFF, 8'h05};
    logic [31:0] nips [3]  = '{32'h00001000, 32'hFFFFFFF0, 32'h0000FFFE};

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 resp_valid in reset", {31'd0, resp_valid}, 32'd0);
        chk("R1 req_ready in reset", {31'd0, req_ready}, 32'd1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 resp_valid after reset", {31'd0, resp_valid}, 32'd0);
        chk("R1 req_ready after reset", {31'd0, req_ready}, 32'd1);

        // Main sweep with the consumer always ready.
        for (int w = 0; w < 2; w++)
            for (int o = 0; o < 7; o++)
                for (int z = 0; z < 2; z++)
                    for (int ci = 0; ci < 10; ci++)
                        for (int di = 0; di < 5; di++)
                            for (int ni = 0; ni < 3; ni++)
                                txn(ops[o], disps[di], cnts[ci], z[0], w[0], nips[ni]);

        // Stall: hold the consumer off while a second request waits.
        @(negedge clk);
        resp_ready = 1'b0;
        drive(8'hE2, 8'hF0, 32'h00000005, 1'b0, 1'b1, 32'h00002000);
        @(posedge clk);
        @(negedge clk);
        drive(8'hE1, 8'h10, 32'h00000001, 1'b1, 1'b1, 32'h00003000);
        chk("R2 ready low while stalled", {31'd0, req_ready}, 32'd0);
        check_result(8'hE2, 8'hF0, 32'h00000005, 1'b0, 1'b1, 32'h00002000);
        repeat (3) @(negedge clk);
        chk("R2 ready still low", {31'd0, req_ready}, 32'd0);
        check_result(8'hE2, 8'hF0, 32'h00000005, 1'b0, 1'b1, 32'h00002000);
        resp_ready = 1'b1;
        #1;
        chk("R2 ready when drained", {31'd0, req_ready}, 32'd1);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check_result(8'hE1, 8'h10, 32'h00000001, 1'b1, 1'b1, 32'h00003000);
        @(posedge clk);
        @(negedge clk);
        chk("R2 valid drops after drain", {31'd0, resp_valid}, 32'd0);

        finish_run();
    end

endmodule